// File: doc/BRIEF.md
# Vectored Call-Feeding Interrupt Controller

This block sits on the bus of an 8-bit CPU. It collects eight interrupt requests and resolves their priority. It answers the CPU's interrupt acknowledge by supplying a complete three-byte subroutine call. The CPU reads the call opcode during the acknowledge cycle. It fetches the two address bytes as ordinary memory reads. During those reads the controller answers in place of main memory and raises an inhibit output so that memory stays off the data bus. The inhibit window closes when the CPU starts its next opcode fetch.

Each request line has a 16-bit target address register and an enable bit. The CPU programs both through I/O writes. Once the controller accepts an interrupt, that source stays in service and no further interrupt is offered. The in-service state clears only when the controller sees the two-byte return-from-interrupt instruction on consecutive opcode fetches. All CPU bus strobes are sampled on the controller clock, and that clock must run several times faster than the bus cycles.

Top module: `vic_top`

## Requirements
- R1: An acknowledge (m1_ni and iorq_ni both low) that begins while an enabled request is pending and nothing is in service is accepted. During that cycle data_o = 0xCD and data_oe_o = 1. An acknowledge that begins when nothing can be accepted drives nothing.
- R2: After acceptance, the first memory read (mreq_ni and rd_ni low, m1_ni high) returns bits 7:0 of the winner's address register. The second memory read returns bits 15:8. data_oe_o is high during both reads.
- R3: mem_inh_o rises when an acknowledge is accepted. It stays high until an opcode fetch (m1_ni and mreq_ni low) begins, and then it falls.
- R4: Exactly three bytes are supplied. A third or later memory read inside the inhibit window leaves data_oe_o low while mem_inh_o stays high.
- R5: An I/O write (iorq_ni and wr_ni low, m1_ni high) to port BASE+2i loads bits 7:0 of the address register of input i, and port BASE+2i+1 loads bits 15:8. Port BASE+16 loads the enable mask, in which bit i enables input i. With the default BASE of 0x40, the mask is at 0x50. All registers reset to zero.
- R6: Among enabled pending inputs, the lowest index wins. The winner is fixed when the acknowledge is accepted, so a request that arrives later does not change the bytes that follow.
- R7: After acceptance, int_no stays high and acknowledges are ignored until an opcode fetch of 0xED is immediately followed by an opcode fetch of 0x4D. A 0x4D alone, or a 0xED followed by any other byte, does not re-arm.
- R8: Request inputs are level-sensitive and pass through a two-flop synchroniser. int_no is low exactly when some enabled request is pending and nothing is in service.
- R9: While rst_ni is low, int_no = 1, mem_inh_o = 0 and data_oe_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock, faster than the CPU bus cycles |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Interrupt request lines, level-sensitive, active high |
| m1_ni | input | 1 | CPU opcode-fetch / acknowledge strobe, active low |
| iorq_ni | input | 1 | CPU I/O request, active low |
| mreq_ni | input | 1 | CPU memory request, active low |
| rd_ni | input | 1 | CPU read strobe, active low |
| wr_ni | input | 1 | CPU write strobe, active low |
| addr_i | input | 8 | Low byte of the CPU address bus (I/O port number) |
| data_i | input | 8 | CPU data bus, as seen by the controller |
| data_o | output | 8 | Byte the controller places on the data bus |
| data_oe_o | output | 1 | Enable for the external data bus driver |
| mem_inh_o | output | 1 | Keeps main memory off the bus, active high |
| int_no | output | 1 | Interrupt request to the CPU, active low |

## Verification
Most internal errors show up on data_o within the same bus cycle. A wrong winner or a corrupted vector register puts a wrong address byte on data_o two bus cycles after the acknowledge. A miscounted byte index either drives a fourth byte or drops the high byte. A feeding flag that clears too early or too late appears as an inhibit edge on the wrong side of the next opcode fetch.

A stuck or wrongly cleared in-service state shows on int_no. It either re-asserts before the return sequence completes or never returns, and this is visible within a few clocks of the relevant fetch. The bench runs the full sequence for several request patterns, for masking, and for a request that arrives in the middle of a sequence. It also covers partial return sequences.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam logic [7:0] OP_CALL   = 8'hCD;
  localparam logic [7:0] OP_PREFIX = 8'hED;
  localparam logic [7:0] OP_RETI   = 8'h4D;

  typedef struct packed {
    logic       m1_n;
    logic       iorq_n;
    logic       mreq_n;
    logic       rd_n;
    logic       wr_n;
    logic [7:0] addr;
    logic [7:0] data;
  } bus_t;
endpackage

// File: rtl/vic_bus.sv
module vic_bus
  import vic_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  bus_t       bus_i,
  output logic       ack_lvl_o,
  output logic       ack_start_o,
  output logic       ack_end_o,
  output logic       mrd_lvl_o,
  output logic       mrd_end_o,
  output logic       fetch_start_o,
  output logic       fetch_end_o,
  output logic       iowr_start_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic [7:0] fetch_byte_o
);
  bus_t       bus_q;
  logic [3:0] lvl, lvl_q;
  logic [7:0] fetch_data_q;

  // 0:ack 1:mem read 2:opcode fetch 3:io write
  always_comb begin
    lvl[0] = !bus_q.m1_n && !bus_q.iorq_n;
    lvl[1] = !bus_q.mreq_n && !bus_q.rd_n && bus_q.m1_n;
    lvl[2] = !bus_q.m1_n && !bus_q.mreq_n;
    lvl[3] = !bus_q.iorq_n && !bus_q.wr_n && bus_q.m1_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_q        <= '{m1_n:1'b1, iorq_n:1'b1, mreq_n:1'b1, rd_n:1'b1,
                        wr_n:1'b1, addr:8'h00, data:8'h00};
      lvl_q        <= '0;
      fetch_data_q <= '0;
    end else begin
      bus_q <= bus_i;
      lvl_q <= lvl;
      if (lvl[2]) fetch_data_q <= bus_q.data;
    end
  end

  assign ack_lvl_o     = lvl[0];
  assign ack_start_o   = lvl[0] && !lvl_q[0];
  assign ack_end_o     = !lvl[0] && lvl_q[0];
  assign mrd_lvl_o     = lvl[1];
  assign mrd_end_o     = !lvl[1] && lvl_q[1];
  assign fetch_start_o = lvl[2] && !lvl_q[2];
  assign fetch_end_o   = !lvl[2] && lvl_q[2];
  assign iowr_start_o  = lvl[3] && !lvl_q[3];
  assign wr_addr_o     = bus_q.addr;
  assign wr_data_o     = bus_q.data;
  assign fetch_byte_o  = fetch_data_q;
endmodule

// File: rtl/vic_regs.sv
module vic_regs #(
  parameter int         N_IRQ     = 8,
  parameter logic [7:0] BASE_PORT = 8'h40
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [7:0]             addr_i,
  input  logic [7:0]             data_i,
  output logic [N_IRQ-1:0][15:0] vec_o,
  output logic [N_IRQ-1:0]       en_o
);
  localparam logic [7:0] MASK_OFF = 8'(2 * N_IRQ);

  logic [7:0] off;
  logic       in_win;

  assign off    = addr_i - BASE_PORT;
  assign in_win = we_i && (addr_i >= BASE_PORT);

  for (genvar i = 0; i < N_IRQ; i++) begin : g_vec
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vec_o[i] <= '0;
      else if (in_win && off == 8'(2 * i))     vec_o[i][7:0]  <= data_i;
      else if (in_win && off == 8'(2 * i + 1)) vec_o[i][15:8] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_o <= '0;
    else if (in_win && off == MASK_OFF) en_o <= data_i[N_IRQ-1:0];
  end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int N_IRQ = 8,
  localparam int IDX_W = $clog2(N_IRQ)
) (
  input  logic [N_IRQ-1:0] pend_i,
  output logic [IDX_W-1:0] grant_idx_o,
  output logic             grant_vld_o
);
  always_comb begin
    grant_idx_o = '0;
    grant_vld_o = 1'b0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        grant_idx_o = IDX_W'(i);
        grant_vld_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vic_seq.sv
module vic_seq
  import vic_pkg::*;
#(
  parameter int N_IRQ = 8,
  localparam int IDX_W = $clog2(N_IRQ)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ack_lvl_i,
  input  logic                   ack_start_i,
  input  logic                   ack_end_i,
  input  logic                   mrd_lvl_i,
  input  logic                   mrd_end_i,
  input  logic                   fetch_start_i,
  input  logic                   fetch_end_i,
  input  logic [7:0]             fetch_byte_i,
  input  logic [IDX_W-1:0]       grant_idx_i,
  input  logic                   grant_vld_i,
  input  logic [N_IRQ-1:0][15:0] vec_i,
  output logic [7:0]             data_o,
  output logic                   data_oe_o,
  output logic                   mem_inh_o,
  output logic                   busy_o
);
  logic             feeding_q, prefix_q;
  logic [1:0]       idx_q;          // 0:opcode 1:low 2:high 3:done
  logic [IDX_W-1:0] win_q;
  logic [N_IRQ-1:0] in_svc_q;
  logic             accept, reti;

  assign busy_o = |in_svc_q;
  assign accept = ack_start_i && grant_vld_i && !busy_o;
  assign reti   = fetch_end_i && prefix_q && fetch_byte_i == OP_RETI && !feeding_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      feeding_q <= 1'b0;
      idx_q     <= '0;
      win_q     <= '0;
      in_svc_q  <= '0;
      prefix_q  <= 1'b0;
    end else begin
      if (accept) begin
        feeding_q          <= 1'b1;
        idx_q              <= 2'd0;
        win_q              <= grant_idx_i;
        in_svc_q[grant_idx_i] <= 1'b1;
      end else if (feeding_q && fetch_start_i) begin
        feeding_q <= 1'b0;
        idx_q     <= 2'd0;
      end else if (feeding_q && ack_end_i && idx_q == 2'd0) begin
        idx_q <= 2'd1;
      end else if (feeding_q && mrd_end_i && idx_q != 2'd0 && idx_q != 2'd3) begin
        idx_q <= idx_q + 2'd1;
      end
      if (fetch_end_i) prefix_q <= (fetch_byte_i == OP_PREFIX);
      if (reti) in_svc_q <= '0;
    end
  end

  always_comb begin
    unique case (idx_q)
      2'd1:    data_o = vec_i[win_q][7:0];
      2'd2:    data_o = vec_i[win_q][15:8];
      default: data_o = OP_CALL;
    endcase
  end

  assign data_oe_o = feeding_q && ((ack_lvl_i && idx_q == 2'd0) ||
                                   (mrd_lvl_i && (idx_q == 2'd1 || idx_q == 2'd2)));
  assign mem_inh_o = feeding_q;

  p_rise_on_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(feeding_q) |-> $past(ack_start_i));
  p_fetch_ends_feed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feeding_q && fetch_start_i |=> !feeding_q);
  p_winner_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feeding_q && $past(feeding_q) |-> $stable(win_q));
  p_one_in_service_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(in_svc_q));
  p_byte_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q == 2'd3 |-> !data_oe_o);
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int         N_IRQ     = 8,
  parameter logic [7:0] BASE_PORT = 8'h40,
  localparam int        IDX_W     = $clog2(N_IRQ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] req_i,
  input  logic             m1_ni,
  input  logic             iorq_ni,
  input  logic             mreq_ni,
  input  logic             rd_ni,
  input  logic             wr_ni,
  input  logic [7:0]       addr_i,
  input  logic [7:0]       data_i,
  output logic [7:0]       data_o,
  output logic             data_oe_o,
  output logic             mem_inh_o,
  output logic             int_no
);
  bus_t                   bus;
  logic [N_IRQ-1:0]       req_s1, req_s2, en, pend;
  logic [N_IRQ-1:0][15:0] vec;
  logic                   ack_lvl, ack_start, ack_end, mrd_lvl, mrd_end;
  logic                   fetch_start, fetch_end, iowr_start;
  logic [7:0]             wr_addr, wr_data, fetch_byte;
  logic [IDX_W-1:0]       grant_idx;
  logic                   grant_vld, busy;

  assign bus = '{m1_n:m1_ni, iorq_n:iorq_ni, mreq_n:mreq_ni, rd_n:rd_ni,
                 wr_n:wr_ni, addr:addr_i, data:data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_s1 <= '0;
      req_s2 <= '0;
    end else begin
      req_s1 <= req_i;
      req_s2 <= req_s1;
    end
  end

  assign pend   = req_s2 & en;
  assign int_no = !(|pend && !busy);

  vic_bus i_bus (
    .clk_i, .rst_ni, .bus_i(bus),
    .ack_lvl_o(ack_lvl), .ack_start_o(ack_start), .ack_end_o(ack_end),
    .mrd_lvl_o(mrd_lvl), .mrd_end_o(mrd_end),
    .fetch_start_o(fetch_start), .fetch_end_o(fetch_end),
    .iowr_start_o(iowr_start), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .fetch_byte_o(fetch_byte)
  );

  vic_regs #(.N_IRQ(N_IRQ), .BASE_PORT(BASE_PORT)) i_regs (
    .clk_i, .rst_ni, .we_i(iowr_start), .addr_i(wr_addr), .data_i(wr_data),
    .vec_o(vec), .en_o(en)
  );

  vic_prio #(.N_IRQ(N_IRQ)) i_prio (
    .pend_i(pend), .grant_idx_o(grant_idx), .grant_vld_o(grant_vld)
  );

  vic_seq #(.N_IRQ(N_IRQ)) i_seq (
    .clk_i, .rst_ni,
    .ack_lvl_i(ack_lvl), .ack_start_i(ack_start), .ack_end_i(ack_end),
    .mrd_lvl_i(mrd_lvl), .mrd_end_i(mrd_end),
    .fetch_start_i(fetch_start), .fetch_end_i(fetch_end),
    .fetch_byte_i(fetch_byte), .grant_idx_i(grant_idx), .grant_vld_i(grant_vld),
    .vec_i(vec), .data_o, .data_oe_o, .mem_inh_o, .busy_o(busy)
  );

  p_inh_masks_int_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_inh_o |-> int_no);
  p_oe_needs_inh_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> mem_inh_o);
endmodule

// File: tb/test_vic_top.sv
module test_vic_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] BASE = 8'h40;

  typedef struct packed {
    logic [7:0] req;
    logic [7:0] en;
    logic [2:0] win;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{req:8'b0000_0001, en:8'hFF, win:3'd0},
    '{req:8'b1000_0000, en:8'hFF, win:3'd7},
    '{req:8'b0110_0100, en:8'hFF, win:3'd2},
    '{req:8'b1111_1110, en:8'hFF, win:3'd1},
    '{req:8'b0000_1100, en:8'hFB, win:3'd3}
  };

  logic clk = 0, rst_ni = 0;
  logic [7:0] req = '0, addr = '0, din = '0;
  logic m1_n = 1, iorq_n = 1, mreq_n = 1, rd_n = 1, wr_n = 1;
  logic [7:0] dout;
  logic oe, inh, int_n;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vic_top i_vic_top (
    .clk_i(clk), .rst_ni, .req_i(req), .m1_ni(m1_n), .iorq_ni(iorq_n),
    .mreq_ni(mreq_n), .rd_ni(rd_n), .wr_ni(wr_n), .addr_i(addr), .data_i(din),
    .data_o(dout), .data_oe_o(oe), .mem_inh_o(inh), .int_no(int_n)
  );

  function automatic logic [7:0] lo_of(int i); return 8'h20 + 8'(i * 17); endfunction
  function automatic logic [7:0] hi_of(int i); return 8'hA0 + 8'(i); endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic io_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; iorq_n = 0; wr_n = 0;
    repeat (3) @(negedge clk); iorq_n = 1; wr_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic ack(output logic [7:0] d, output logic e);
    @(negedge clk); m1_n = 0; iorq_n = 0;
    repeat (3) @(negedge clk); d = dout; e = oe; m1_n = 1; iorq_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic mrd(output logic [7:0] d, output logic e, output logic h);
    @(negedge clk); mreq_n = 0; rd_n = 0;
    repeat (3) @(negedge clk); d = dout; e = oe; h = inh; mreq_n = 1; rd_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic fetch(input logic [7:0] b);
    @(negedge clk); din = b; m1_n = 0; mreq_n = 0; rd_n = 0;
    repeat (3) @(negedge clk); m1_n = 1; mreq_n = 1; rd_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_req(input logic [7:0] r);
    req = r; repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic e, h;
    repeat (3) @(negedge clk);
    chk(int_n == 1 && inh == 0 && oe == 0, "R9 reset outputs", {13'd0, int_n, inh, oe}, 16'h0004);
    rst_ni = 1;
    repeat (2) @(negedge clk);

    // R5 enable mask resets to zero: request alone raises nothing
    set_req(8'h01);
    chk(int_n == 1, "R5 mask reset zero", {15'd0, int_n}, 16'h1);
    set_req(8'h00);

    for (int i = 0; i < 8; i++) begin
      io_wr(BASE + 8'(2 * i), lo_of(i));
      io_wr(BASE + 8'(2 * i + 1), hi_of(i));
    end

    foreach (VECS[k]) begin
      io_wr(BASE + 8'd16, VECS[k].en);
      set_req(VECS[k].req);
      chk(int_n == 0, "R8 int asserted", {15'd0, int_n}, 16'h0);
      ack(d, e);
      chk(d == 8'hCD && e == 1, "R1 call opcode", {7'd0, e, d}, 16'h01CD);
      mrd(d, e, h);
      chk(d == lo_of(VECS[k].win) && e, "R2 R6 low byte", {7'd0, e, d}, {8'h01, lo_of(VECS[k].win)});
      mrd(d, e, h);
      chk(d == hi_of(VECS[k].win) && e, "R2 R6 high byte", {7'd0, e, d}, {8'h01, hi_of(VECS[k].win)});
      chk(inh == 1 && int_n == 1, "R3 R7 window open", {14'd0, inh, int_n}, 16'h3);
      fetch(8'h00);
      chk(inh == 0, "R3 fetch closes window", {15'd0, inh}, 16'h0);
      fetch(8'hED);
      fetch(8'h4D);
      chk(int_n == 0, "R7 re-armed after return", {15'd0, int_n}, 16'h0);
      set_req(8'h00);
      chk(int_n == 1, "R8 level request dropped", {15'd0, int_n}, 16'h1);
    end

    // R8 masked-only request
    io_wr(BASE + 8'd16, 8'hFB);
    set_req(8'h04);
    chk(int_n == 1, "R8 masked request ignored", {15'd0, int_n}, 16'h1);
    set_req(8'h00);

    // R1 acknowledge with nothing pending
    io_wr(BASE + 8'd16, 8'hFF);
    ack(d, e);
    chk(e == 0 && inh == 0, "R1 idle acknowledge", {14'd0, e, inh}, 16'h0);

    // R6 latch: higher request arrives mid-sequence; R4 fourth read
    set_req(8'h10);
    ack(d, e);
    set_req(8'h11);
    mrd(d, e, h);
    chk(d == lo_of(4), "R6 latched low", {8'd0, d}, {8'd0, lo_of(4)});
    mrd(d, e, h);
    chk(d == hi_of(4), "R6 latched high", {8'd0, d}, {8'd0, hi_of(4)});
    mrd(d, e, h);
    chk(e == 0 && h == 1, "R4 no fourth byte", {14'd0, e, h}, 16'h1);
    ack(d, e);
    chk(e == 0, "R7 acknowledge ignored in service", {15'd0, e}, 16'h0);
    fetch(8'h00);
    chk(int_n == 1, "R7 no rearm before return", {15'd0, int_n}, 16'h1);
    fetch(8'h4D);
    chk(int_n == 1, "R7 lone 4D ignored", {15'd0, int_n}, 16'h1);
    fetch(8'hED);
    fetch(8'h00);
    fetch(8'h4D);
    chk(int_n == 1, "R7 broken pair ignored", {15'd0, int_n}, 16'h1);
    fetch(8'hED);
    fetch(8'h4D);
    chk(int_n == 0, "R7 pair re-arms", {15'd0, int_n}, 16'h0);
    ack(d, e);
    mrd(d, e, h);
    chk(d == lo_of(0), "R6 lowest index wins", {8'd0, d}, {8'd0, lo_of(0)});

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule